// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps recently used page translations close to the pipeline. A lookup presents a 32-bit virtual address, an access kind and the context number of the running application. The upper 20 bits, which name the page, are compared against every stored entry in the same cycle. On a hit, the block returns the stored physical page number joined with the untouched 12-bit in-page offset. It also reports whether the entry's permission bits allow the requested access.

After a miss, the agent that walks the page table writes the translation in through the fill port. A fill goes to the entry that already holds the same page and context if there is one. Otherwise it goes to the lowest free entry. When the buffer is full, a round-robin victim is replaced. A single flush input empties the whole buffer, for example when switching applications. Context tags let translations of several applications share the buffer without a flush.

Top module: `xlat_cache`

## Requirements
- R1: On a hit, respPa equals the stored physical page number in bits 31:12 and the lookup address bits 11:0 in bits 11:0; on a miss respPa is zero.
- R2: After reset the buffer holds no entry: respValid, respHit, respFault and respPa are 0, and every lookup misses until a fill has been made.
- R3: Lookup results appear exactly one clock after the lookup is presented; respValid follows lookupValid one cycle later, and respHit and respFault are 0 whenever respValid is 0.
- R4: Access encoding is 00 read, 01 write, 10 execute, 11 reserved. Permission bit 0 allows read, bit 1 write and bit 2 execute. respFault is 1 on a hit whose access is not allowed, and always 1 on a hit with the reserved code. It is never 1 on a miss.
- R5: A hit requires both the page number and the context tag to match; the same page under a different context misses or returns that context's own translation.
- R6: A fill stores its translation at the clock edge; a lookup presented in the same cycle as a fill still sees the contents before that fill, and a later lookup hits.
- R7: A fill for a page and context not present takes the lowest-indexed free entry, so the number of valid entries grows by one.
- R8: A fill whose page and context already match a valid entry overwrites that entry; no two valid entries ever match the same page and context.
- R9: When all entries are valid, a new fill evicts the entry at a round-robin pointer that starts at entry 0 after reset and advances by one, wrapping after the last entry, only on such an eviction.
- R10: flushAll invalidates every entry at the next edge and takes priority over a fill in the same cycle, which is then discarded; the round-robin pointer is not changed by a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | A lookup is presented this cycle |
| lookupVa | input | 32 | Virtual address to translate |
| lookupAcc | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| lookupCtx | input | CTX_W (4) | Context of the requesting application |
| fillValid | input | 1 | Write a translation this cycle |
| fillVpn | input | 20 | Virtual page number of the translation |
| fillCtx | input | CTX_W (4) | Context the translation belongs to |
| fillPpn | input | 20 | Physical page number of the translation |
| fillPerm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| flushAll | input | 1 | Invalidate every entry |
| respValid | output | 1 | A lookup result is present |
| respHit | output | 1 | The lookup matched an entry |
| respPa | output | 32 | Translated physical address |
| respFault | output | 1 | Hit, but the access is not permitted |

## Verification
Every cycle, the assertions check several properties. The response lags its lookup by one cycle, and a fault or hit only comes with a valid response. The offset passes through unchanged, and an empty buffer produces only misses. A flush leaves no valid entry. The count of valid entries rises by one on a fill into a free slot and stays put on an overwrite, and no page and context is ever held twice. Other behaviour only shows in the bench's scenarios: the physical page and permission results for particular contents, the separation of contexts, what a lookup sees in the same cycle as a fill, and the round-robin eviction order once the buffer is full.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VPN_W = 20;
  localparam int OFF_W = 12;
  localparam int PPN_W = 20;
  localparam int IDX_W = 7;   // enough for up to 128 entries

  localparam logic [1:0] ACC_READ  = 2'b00;
  localparam logic [1:0] ACC_WRITE = 2'b01;
  localparam logic [1:0] ACC_EXEC  = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic             wrEn;
    logic             clrAll;
    logic [IDX_W-1:0] wrIdx;
  } strobe_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int NUM_ENTRIES = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   fillValid,
  input  logic                   flushAll,
  input  logic [NUM_ENTRIES-1:0] validVec,
  input  logic [NUM_ENTRIES-1:0] fillMatchVec,
  output strobe_t                strb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] matchIdx, freeIdx;
  logic             anyMatch, anyFree, evict;

  // lowest-indexed matching entry and lowest-indexed free entry
  always_comb begin
    matchIdx = '0;
    anyMatch = 1'b0;
    freeIdx  = '0;
    anyFree  = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (fillMatchVec[i]) begin
        matchIdx = IDX_W'(i);
        anyMatch = 1'b1;
      end
      if (!validVec[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
    end
  end

  always_comb begin
    strb.clrAll = flushAll;
    strb.wrEn   = fillValid && !flushAll;
    if (anyMatch)     strb.wrIdx = matchIdx;
    else if (anyFree) strb.wrIdx = freeIdx;
    else              strb.wrIdx = rrPtr;
  end

  assign evict = strb.wrEn && !anyMatch && !anyFree;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      rrPtr <= '0;
    else if (evict) rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
  end
endmodule

// File: rtl/xlat_dpath.sv
module xlat_dpath
  import xlat_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int CTX_W       = 4,
  parameter bit USE_CTX     = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic                   lookupValid,
  input  logic [31:0]            lookupVa,
  input  logic [1:0]             lookupAcc,
  input  logic [CTX_W-1:0]       lookupCtx,
  input  logic [VPN_W-1:0]       fillVpn,
  input  logic [CTX_W-1:0]       fillCtx,
  input  logic [PPN_W-1:0]       fillPpn,
  input  logic [2:0]             fillPerm,
  output logic [NUM_ENTRIES-1:0] validVec,
  output logic [NUM_ENTRIES-1:0] fillMatchVec,
  output logic                   respValid,
  output logic                   respHit,
  output logic [31:0]            respPa,
  output logic                   respFault
);
  logic [NUM_ENTRIES-1:0] validQ, wrSel, lookMatch, hitOne;
  logic [VPN_W-1:0]       vpnQ  [NUM_ENTRIES];
  logic [CTX_W-1:0]       ctxQ  [NUM_ENTRIES];
  logic [PPN_W-1:0]       ppnQ  [NUM_ENTRIES];
  logic [2:0]             permQ [NUM_ENTRIES];

  logic [PPN_W-1:0] ppnSel;
  logic [2:0]       permSel;
  logic             hitAny, permOk;

  wire [VPN_W-1:0] lookVpn = lookupVa[31:OFF_W];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic lookCtxOk, fillCtxOk;
    if (USE_CTX) begin : g_ctx
      assign lookCtxOk = (ctxQ[g] == lookupCtx);
      assign fillCtxOk = (ctxQ[g] == fillCtx);
    end else begin : g_noctx
      assign lookCtxOk = 1'b1;
      assign fillCtxOk = 1'b1;
    end
    assign lookMatch[g]    = validQ[g] && (vpnQ[g] == lookVpn) && lookCtxOk;
    assign fillMatchVec[g] = validQ[g] && (vpnQ[g] == fillVpn) && fillCtxOk;
    assign wrSel[g]        = strb.wrEn && (strb.wrIdx == IDX_W'(g));
  end

  assign validVec = validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            validQ <= '0;
    else if (strb.clrAll) validQ <= '0;
    else                  validQ <= validQ | wrSel;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (wrSel[i]) begin
        vpnQ[i]  <= fillVpn;
        ctxQ[i]  <= fillCtx;
        ppnQ[i]  <= fillPpn;
        permQ[i] <= fillPerm;
      end
    end
  end

  // lowest-indexed match wins, then an AND-OR read mux
  always_comb begin
    hitOne  = '0;
    hitAny  = 1'b0;
    ppnSel  = '0;
    permSel = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (lookMatch[i] && !hitAny) begin
        hitOne[i] = 1'b1;
        hitAny    = 1'b1;
      end
    end
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (hitOne[i]) begin
        ppnSel  = ppnSel  | ppnQ[i];
        permSel = permSel | permQ[i];
      end
    end
  end

  always_comb begin
    case (lookupAcc)
      ACC_READ:  permOk = permSel[0];
      ACC_WRITE: permOk = permSel[1];
      ACC_EXEC:  permOk = permSel[2];
      default:   permOk = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respFault <= 1'b0;
      respPa    <= '0;
    end else begin
      respValid <= lookupValid;
      respHit   <= lookupValid && hitAny;
      respFault <= lookupValid && hitAny && !permOk;
      respPa    <= (lookupValid && hitAny) ? {ppnSel, lookupVa[OFF_W-1:0]} : '0;
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int CTX_W       = 4,
  parameter bit USE_CTX     = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [31:0]      lookupVa,
  input  logic [1:0]       lookupAcc,
  input  logic [CTX_W-1:0] lookupCtx,
  input  logic             fillValid,
  input  logic [19:0]      fillVpn,
  input  logic [CTX_W-1:0] fillCtx,
  input  logic [19:0]      fillPpn,
  input  logic [2:0]       fillPerm,
  input  logic             flushAll,
  output logic             respValid,
  output logic             respHit,
  output logic [31:0]      respPa,
  output logic             respFault
);
  strobe_t                strb;
  logic [NUM_ENTRIES-1:0] validVec, fillMatchVec;

  xlat_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .fillValid(fillValid), .flushAll(flushAll),
    .validVec(validVec), .fillMatchVec(fillMatchVec), .strb(strb)
  );

  xlat_dpath #(.NUM_ENTRIES(NUM_ENTRIES), .CTX_W(CTX_W), .USE_CTX(USE_CTX)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .lookupValid(lookupValid), .lookupVa(lookupVa), .lookupAcc(lookupAcc),
    .lookupCtx(lookupCtx), .fillVpn(fillVpn), .fillCtx(fillCtx),
    .fillPpn(fillPpn), .fillPerm(fillPerm),
    .validVec(validVec), .fillMatchVec(fillMatchVec),
    .respValid(respValid), .respHit(respHit), .respPa(respPa), .respFault(respFault)
  );
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
  import xlat_pkg::*;
#(
  parameter int NUM_ENTRIES = 64
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   lookupValid,
  input logic [31:0]            lookupVa,
  input logic                   flushAll,
  input logic                   respValid,
  input logic                   respHit,
  input logic [31:0]            respPa,
  input logic                   respFault,
  input logic [NUM_ENTRIES-1:0] validVec,
  input logic [NUM_ENTRIES-1:0] fillMatchVec,
  input strobe_t                strb
);
  p_offset_r1: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> (!respHit || respPa[11:0] == $past(lookupVa[11:0])));

  p_empty_miss_r2: assert property (@(posedge clk) disable iff (!rstN)
    (validVec == '0) |=> !respHit);

  p_resp_follows_r3: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);

  p_no_resp_r3: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> (!respValid && !respHit && !respFault));

  p_fault_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    respFault |-> respHit);

  p_fill_free_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && fillMatchVec == '0 && !(&validVec))
      |=> ($countones(validVec) == $countones($past(validVec)) + 1));

  p_overwrite_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && fillMatchVec != '0) |=> (validVec == $past(validVec)));

  p_unique_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fillMatchVec));

  p_flush_r10: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> (validVec == '0));
endmodule

bind xlat_cache xlat_cache_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVa(lookupVa),
  .flushAll(flushAll), .respValid(respValid), .respHit(respHit),
  .respPa(respPa), .respFault(respFault), .validVec(validVec),
  .fillMatchVec(fillMatchVec), .strb(strb)
);

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;
  localparam int ENTRIES = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupVa = '0;
  logic [1:0]  lookupAcc = '0;
  logic [3:0]  lookupCtx = '0;
  logic        fillValid = 1'b0;
  logic [19:0] fillVpn = '0;
  logic [3:0]  fillCtx = '0;
  logic [19:0] fillPpn = '0;
  logic [2:0]  fillPerm = '0;
  logic        flushAll = 1'b0;
  logic        respValid, respHit, respFault;
  logic [31:0] respPa;

  int nTests = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  xlat_cache #(.NUM_ENTRIES(ENTRIES), .CTX_W(4), .USE_CTX(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVa(lookupVa),
    .lookupAcc(lookupAcc), .lookupCtx(lookupCtx), .fillValid(fillValid),
    .fillVpn(fillVpn), .fillCtx(fillCtx), .fillPpn(fillPpn), .fillPerm(fillPerm),
    .flushAll(flushAll), .respValid(respValid), .respHit(respHit),
    .respPa(respPa), .respFault(respFault)
  );

  // {va, acc, ctx, expHit, expFault, expPa}
  localparam int NVEC = 11;
  localparam logic [71:0] VEC [NVEC] = '{
    {32'h00003ABC, 2'b00, 4'd1, 1'b1, 1'b0, 32'h02000ABC},
    {32'h00003ABC, 2'b01, 4'd1, 1'b1, 1'b0, 32'h02000ABC},
    {32'h00003000, 2'b10, 4'd1, 1'b1, 1'b1, 32'h02000000},
    {32'h01000FFF, 2'b01, 4'd1, 1'b1, 1'b1, 32'h00130FFF},
    {32'h01000FFF, 2'b00, 4'd2, 1'b1, 1'b0, 32'h00555FFF},
    {32'h01000010, 2'b10, 4'd2, 1'b1, 1'b0, 32'h00555010},
    {32'h01000010, 2'b00, 4'd3, 1'b0, 1'b0, 32'h00000000},
    {32'hFFFFF123, 2'b10, 4'd1, 1'b1, 1'b0, 32'hABCDE123},
    {32'hFFFFF123, 2'b00, 4'd1, 1'b1, 1'b1, 32'hABCDE123},
    {32'h00004000, 2'b00, 4'd1, 1'b0, 1'b0, 32'h00000000},
    {32'h00003000, 2'b11, 4'd1, 1'b1, 1'b1, 32'h02000000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doFill(input logic [19:0] vpn, input logic [3:0] ctx,
                        input logic [19:0] ppn, input logic [2:0] perm);
    @(negedge clk);
    fillValid = 1'b1; fillVpn = vpn; fillCtx = ctx; fillPpn = ppn; fillPerm = perm;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic doLook(input logic [31:0] va, input logic [1:0] acc, input logic [3:0] ctx);
    @(negedge clk);
    lookupValid = 1'b1; lookupVa = va; lookupAcc = acc; lookupCtx = ctx;
    @(negedge clk);
    lookupValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 respValid after reset", 32'(respValid), 32'd0);
    check("R2 respHit after reset", 32'(respHit), 32'd0);
    check("R2 respPa after reset", respPa, 32'd0);
    rstN = 1'b1;
    doLook(32'h00003ABC, 2'b00, 4'd1);
    check("R2 empty lookup valid", 32'(respValid), 32'd1);
    check("R2 empty lookup misses", 32'(respHit), 32'd0);

    doFill(20'h00003, 4'd1, 20'h02000, 3'b011);
    doFill(20'h01000, 4'd1, 20'h00130, 3'b001);
    doFill(20'h01000, 4'd2, 20'h00555, 3'b101);
    doFill(20'hFFFFF, 4'd1, 20'hABCDE, 3'b100);

    // R1 R4 R5: table walk
    for (int k = 0; k < NVEC; k++) begin
      doLook(VEC[k][71:40], VEC[k][39:38], VEC[k][37:34]);
      check($sformatf("R1 R5 hit vec %0d", k), 32'(respHit), 32'(VEC[k][33]));
      check($sformatf("R4 fault vec %0d", k), 32'(respFault), 32'(VEC[k][32]));
      check($sformatf("R1 pa vec %0d", k), respPa, VEC[k][31:0]);
    end

    // R3: no lookup, no response
    @(negedge clk);
    lookupVa = 32'h00003000; lookupAcc = 2'b10; lookupCtx = 4'd1;
    @(negedge clk);
    check("R3 idle respValid", 32'(respValid), 32'd0);
    check("R3 idle respFault", 32'(respFault), 32'd0);

    // R6: lookup in same cycle as fill sees old contents
    @(negedge clk);
    fillValid = 1'b1; fillVpn = 20'h00050; fillCtx = 4'd1; fillPpn = 20'h00060; fillPerm = 3'b001;
    lookupValid = 1'b1; lookupVa = 32'h00050004; lookupAcc = 2'b00; lookupCtx = 4'd1;
    @(negedge clk);
    fillValid = 1'b0; lookupValid = 1'b0;
    check("R6 same-cycle lookup misses", 32'(respHit), 32'd0);
    doLook(32'h00050004, 2'b00, 4'd1);
    check("R6 later lookup pa", respPa, 32'h00060004);

    // R8: overwrite wins over the older entry
    doFill(20'h00003, 4'd1, 20'h07777, 3'b001);
    doLook(32'h00003010, 2'b01, 4'd1);
    check("R8 overwritten pa", respPa, 32'h07777010);
    check("R8 overwritten perms", 32'(respFault), 32'd1);

    // R10: flush with simultaneous fill
    @(negedge clk);
    flushAll = 1'b1;
    fillValid = 1'b1; fillVpn = 20'h00070; fillCtx = 4'd1; fillPpn = 20'h00071; fillPerm = 3'b001;
    @(negedge clk);
    flushAll = 1'b0; fillValid = 1'b0;
    doLook(32'h01000000, 2'b00, 4'd2);
    check("R10 flushed entry misses", 32'(respHit), 32'd0);
    doLook(32'h00070000, 2'b00, 4'd1);
    check("R10 fill with flush discarded", 32'(respHit), 32'd0);

    // R7 R9: fill every entry, then evict in round-robin order
    for (int i = 0; i < ENTRIES; i++)
      doFill(20'h00100 + 20'(i), 4'd1, 20'h00300 + 20'(i), 3'b001);
    doLook(32'h0013F000, 2'b00, 4'd1);
    check("R7 last free entry filled", respPa, 32'h0033F000);
    doFill(20'h00900, 4'd1, 20'h00901, 3'b001);
    doLook(32'h00100000, 2'b00, 4'd1);
    check("R9 entry 0 evicted", 32'(respHit), 32'd0);
    doLook(32'h00101000, 2'b00, 4'd1);
    check("R9 entry 1 kept", respPa, 32'h00301000);
    doLook(32'h00900000, 2'b00, 4'd1);
    check("R9 new page present", respPa, 32'h00901000);
    doFill(20'h00A00, 4'd1, 20'h00A01, 3'b001);
    doLook(32'h00101000, 2'b00, 4'd1);
    check("R9 entry 1 evicted next", 32'(respHit), 32'd0);
    // R8 R9: overwrite while full does not move the pointer
    doFill(20'h00102, 4'd1, 20'h00777, 3'b001);
    doLook(32'h00102000, 2'b00, 4'd1);
    check("R8 overwrite when full", respPa, 32'h00777000);
    doFill(20'h00B00, 4'd1, 20'h00B01, 3'b001);
    doLook(32'h00102000, 2'b00, 4'd1);
    check("R9 pointer held on overwrite", 32'(respHit), 32'd0);
    doLook(32'h00103000, 2'b00, 4'd1);
    check("R9 entry 3 kept", respPa, 32'h00303000);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule